// File: doc/BRIEF.md
# Pipeline Stall and Hazard Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The pipeline can only see read-after-write dependencies. Write-after-read and write-after-write orderings cannot arise when instructions complete in order, so they need no handling.

The block takes stall requests from the decode and execute stages. It turns them into a six-bit freeze vector: bit 0 holds the program counter, and bits 1 to 5 hold the fetch, decode, execute, memory and writeback stage registers. A request raised by a stage freezes the program counter and every stage up to and including that stage. The stages after it keep advancing, and the stage register right after the last frozen one is told to load a NOP (all-zero control).

Inside the block, a decode-time load-use check raises a decode stall when the instruction now in execute is a load whose destination register is read by the instruction in decode. A bypass network, one copy per register read port, replaces the register-file value with an in-flight result from the execute or memory stage.

The block is purely combinational. It chooses one of three hold modes each cycle:
- `MODE_RUN`: no request is active.
- `MODE_HOLD_ID`: a decode request or a load-use hazard is active and there is no execute request.
- `MODE_HOLD_EX`: an execute request is active, whatever else is asserted.

The mode is re-chosen from the current inputs every cycle. Any mode can go to any other when the requests change.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: With no decode request, no execute request and no load-use hazard, `stall_vec` is 6'b000000 and `nop_inject` is 6'b000000.
- R2: A decode request with no execute request gives `stall_vec` = 6'b000111 (PC, fetch, decode frozen) and `nop_inject` = 6'b001000 (execute register loads a NOP).
- R3: An execute request gives `stall_vec` = 6'b001111 and `nop_inject` = 6'b010000, whether or not a decode request or a load-use hazard is also present.
- R4: `stall_vec` is always a thermometer code from bit 0 upward. Bit 0 (the program counter hold) is set whenever any bit is set.
- R5: A load-use hazard produces the same outputs as R2 when there is no execute request. The hazard exists when `ex_is_load` and `ex_wreg` are 1, `ex_waddr` is nonzero, and some port p has `rd_en[p]` = 1 and address field p equal to `ex_waddr`.
- R6: No load-use stall is raised when the instruction in execute is not a load, does not write, or targets register 0. None is raised either when the matching port is disabled.
- R7: For an enabled port with a nonzero address, `ex_wreg` = 1 and `ex_waddr` equal to the address, the port's operand is `ex_wdata`.
- R8: If R7 does not apply to an enabled port with a nonzero address, and `mem_wreg` = 1 with `mem_waddr` equal to the address, the operand is `mem_wdata`. The execute result wins when both stages match.
- R9: For an enabled port with a nonzero address and no match in execute or memory, the operand is that port's `rf_rdata` field.
- R10: A port whose address is 0 yields an all-zero operand, regardless of enable, stage writes or register-file data.
- R11: A disabled port with a nonzero address passes its `rf_rdata` field through unchanged, even when an execute or memory destination matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_stall_req | input | 1 | Stall request from the decode stage |
| exe_stall_req | input | 1 | Stall request from the execute stage |
| rd_en | input | NPORTS | Read-port enables of the decode instruction |
| rd_addr | input | NPORTS*AW | Read-port register addresses, port p in bits [p*AW +: AW] |
| rf_rdata | input | NPORTS*DW | Register-file read data, port p in bits [p*DW +: DW] |
| ex_wreg | input | 1 | Execute-stage instruction writes a register |
| ex_waddr | input | AW | Execute-stage destination register |
| ex_wdata | input | DW | Execute-stage result |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_wreg | input | 1 | Memory-stage instruction writes a register |
| mem_waddr | input | AW | Memory-stage destination register |
| mem_wdata | input | DW | Memory-stage result |
| stall_vec | output | 6 | Freeze vector: bit 0 PC, bits 1..5 fetch..writeback |
| nop_inject | output | 6 | Stage register that loads a NOP this cycle, same bit order |
| operand | output | NPORTS*DW | Bypassed operands, port p in bits [p*DW +: DW] |

## Verification
The bench builds the block with AW = 2, DW = 8 and NPORTS = 2. Four registers and two ports are small enough to sweep every combination of the two request inputs, both port enables and addresses, the execute-stage write, load and destination fields, and the memory-stage write and destination: 32768 input patterns in all. That range contains every collision that matters. These include both ports hitting the same destination, execute and memory matching the same register, matches on register 0, and load-use hazards coinciding with either request. Each result is compared with values worked out in the bench from the requirement rules.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int STALL_W = 6;

    // Stage positions inside the freeze vector; the order is the pipeline order.
    localparam int ST_PC  = 0;
    localparam int ST_IF  = 1;
    localparam int ST_ID  = 2;
    localparam int ST_EX  = 3;
    localparam int ST_MEM = 4;
    localparam int ST_WB  = 5;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_HOLD_ID = 2'd1,
        MODE_HOLD_EX = 2'd2
    } hold_mode_e;

    // Bits 0..last set: everything up to and including stage 'last' holds.
    function automatic logic [STALL_W-1:0] freeze_upto(input int last);
        logic [STALL_W-1:0] m;
        for (int i = 0; i < STALL_W; i++) begin
            m[i] = (i <= last);
        end
        return m;
    endfunction

    function automatic logic [STALL_W-1:0] stage_bit(input int idx);
        logic [STALL_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int AW     = 5,
    parameter int NPORTS = 2
) (
    input  logic [NPORTS-1:0]    rd_en,
    input  logic [NPORTS*AW-1:0] rd_addr,
    input  logic                 ex_is_load,
    input  logic                 ex_wreg,
    input  logic [AW-1:0]        ex_waddr,
    output logic                 hazard
);

    logic [NPORTS-1:0] port_hit;
    logic              load_dest_live;

    // Register 0 is never a dependency source.
    assign load_dest_live = ex_is_load && ex_wreg && (ex_waddr != '0);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_hit[p] = rd_en[p] && (rd_addr[p*AW +: AW] == ex_waddr);
    end

    assign hazard = load_dest_live && (|port_hit);

endmodule

// File: rtl/hz_bypass.sv
module hz_bypass #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rf_rdata,
    input  logic          ex_wreg,
    input  logic [AW-1:0] ex_waddr,
    input  logic [DW-1:0] ex_wdata,
    input  logic          mem_wreg,
    input  logic [AW-1:0] mem_waddr,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] operand
);

    logic hit_ex;
    logic hit_mem;

    assign hit_ex  = rd_en && ex_wreg  && (ex_waddr  == rd_addr);
    assign hit_mem = rd_en && mem_wreg && (mem_waddr == rd_addr);

    // Priority: register 0, then the younger execute result, then memory.
    always_comb begin
        if (rd_addr == '0) begin
            operand = '0;
        end else if (hit_ex) begin
            operand = ex_wdata;
        end else if (hit_mem) begin
            operand = mem_wdata;
        end else begin
            operand = rf_rdata;
        end
    end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
(
    input  logic               id_req,
    input  logic               ex_req,
    output hold_mode_e         mode,
    output logic [STALL_W-1:0] stall_vec,
    output logic [STALL_W-1:0] nop_inject
);

    // Mode selection: the deeper requester wins.
    always_comb begin
        if (ex_req) begin
            mode = MODE_HOLD_EX;
        end else if (id_req) begin
            mode = MODE_HOLD_ID;
        end else begin
            mode = MODE_RUN;
        end
    end

    // Outputs per mode.
    always_comb begin
        unique case (mode)
            MODE_RUN: begin
                stall_vec  = '0;
                nop_inject = '0;
            end
            MODE_HOLD_ID: begin
                stall_vec  = freeze_upto(ST_ID);
                nop_inject = stage_bit(ST_EX);
            end
            MODE_HOLD_EX: begin
                stall_vec  = freeze_upto(ST_EX);
                nop_inject = stage_bit(ST_MEM);
            end
            default: begin
                stall_vec  = '0;
                nop_inject = '0;
            end
        endcase
    end

endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl #(
    parameter int AW     = 5,
    parameter int DW     = 32,
    parameter int NPORTS = 2
) (
    input  logic                 dec_stall_req,
    input  logic                 exe_stall_req,
    input  logic [NPORTS-1:0]    rd_en,
    input  logic [NPORTS*AW-1:0] rd_addr,
    input  logic [NPORTS*DW-1:0] rf_rdata,
    input  logic                 ex_wreg,
    input  logic [AW-1:0]        ex_waddr,
    input  logic [DW-1:0]        ex_wdata,
    input  logic                 ex_is_load,
    input  logic                 mem_wreg,
    input  logic [AW-1:0]        mem_waddr,
    input  logic [DW-1:0]        mem_wdata,
    output logic [5:0]           stall_vec,
    output logic [5:0]           nop_inject,
    output logic [NPORTS*DW-1:0] operand
);

    import hz_pkg::*;

    logic       load_hazard;
    logic       id_req_all;
    hold_mode_e mode;

    hz_load_use #(
        .AW     (AW),
        .NPORTS (NPORTS)
    ) u_load_use (
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .ex_is_load (ex_is_load),
        .ex_wreg    (ex_wreg),
        .ex_waddr   (ex_waddr),
        .hazard     (load_hazard)
    );

    assign id_req_all = dec_stall_req || load_hazard;

    hz_stall_ctrl u_stall (
        .id_req     (id_req_all),
        .ex_req     (exe_stall_req),
        .mode       (mode),
        .stall_vec  (stall_vec),
        .nop_inject (nop_inject)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_byp
        hz_bypass #(
            .AW (AW),
            .DW (DW)
        ) u_byp (
            .rd_en     (rd_en[p]),
            .rd_addr   (rd_addr[p*AW +: AW]),
            .rf_rdata  (rf_rdata[p*DW +: DW]),
            .ex_wreg   (ex_wreg),
            .ex_waddr  (ex_waddr),
            .ex_wdata  (ex_wdata),
            .mem_wreg  (mem_wreg),
            .mem_waddr (mem_waddr),
            .mem_wdata (mem_wdata),
            .operand   (operand[p*DW +: DW])
        );
    end

endmodule

// File: rtl/hz_pipe_ctrl_chk.sv
module hz_pipe_ctrl_chk #(
    parameter int AW     = 5,
    parameter int DW     = 32,
    parameter int NPORTS = 2
) (
    input logic                 dec_stall_req,
    input logic                 exe_stall_req,
    input logic                 load_hazard,
    input logic [NPORTS-1:0]    rd_en,
    input logic [NPORTS*AW-1:0] rd_addr,
    input logic                 ex_wreg,
    input logic [AW-1:0]        ex_waddr,
    input logic [DW-1:0]        ex_wdata,
    input logic [5:0]           stall_vec,
    input logic [5:0]           nop_inject,
    input logic [NPORTS*DW-1:0] operand
);

    always_comb begin
        // R1: quiet inputs leave the pipeline running.
        a_r1_idle: assert (dec_stall_req || exe_stall_req || load_hazard ||
                           (stall_vec == 6'b0 && nop_inject == 6'b0));
        // R3: execute request dominates.
        a_r3_exec_hold: assert (!exe_stall_req ||
                                (stall_vec == 6'b001111 && nop_inject == 6'b010000));
        // R5: load-use hazard acts as a decode stall.
        a_r5_load_use: assert (!load_hazard || exe_stall_req ||
                               (stall_vec == 6'b000111 && nop_inject == 6'b001000));
        // R4: PC hold accompanies any stall.
        a_r4_pc_hold: assert (stall_vec == 6'b0 || stall_vec[0]);
        // R2: at most one NOP insertion point.
        a_r2_one_nop: assert ($onehot0(nop_inject));
        for (int i = 1; i < 6; i++) begin
            // R4: thermometer shape.
            a_r4_prefix: assert (!stall_vec[i] || stall_vec[i-1]);
            // R2: NOP goes to the first stage that still moves.
            a_r2_nop_edge: assert (!nop_inject[i] || (stall_vec[i-1] && !stall_vec[i]));
        end
        for (int p = 0; p < NPORTS; p++) begin
            // R10: register 0 reads as zero.
            a_r10_zero_reg: assert (rd_addr[p*AW +: AW] != '0 || operand[p*DW +: DW] == '0);
            // R7: execute result forwarded on a live match.
            a_r7_ex_fwd: assert (!(rd_en[p] && ex_wreg && rd_addr[p*AW +: AW] != '0 &&
                                   rd_addr[p*AW +: AW] == ex_waddr) ||
                                 operand[p*DW +: DW] == ex_wdata);
        end
    end

endmodule

bind hz_pipe_ctrl hz_pipe_ctrl_chk #(
    .AW     (AW),
    .DW     (DW),
    .NPORTS (NPORTS)
) u_chk (
    .dec_stall_req (dec_stall_req),
    .exe_stall_req (exe_stall_req),
    .load_hazard   (load_hazard),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .ex_wreg       (ex_wreg),
    .ex_waddr      (ex_waddr),
    .ex_wdata      (ex_wdata),
    .stall_vec     (stall_vec),
    .nop_inject    (nop_inject),
    .operand       (operand)
);

// File: tb/sim_hz_pipe_ctrl.sv
`timescale 1ns/1ps
module sim_hz_pipe_ctrl;

    localparam int TAW = 2;
    localparam int TDW = 8;
    localparam int TNP = 2;
    localparam logic [TDW-1:0] EXV  = 8'h5C;
    localparam logic [TDW-1:0] MEMV = 8'h3E;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic                   dec_stall_req = 1'b0;
    logic                   exe_stall_req = 1'b0;
    logic [TNP-1:0]         rd_en = '0;
    logic [TNP*TAW-1:0]     rd_addr = '0;
    logic [TNP*TDW-1:0]     rf_rdata = '0;
    logic                   ex_wreg = 1'b0;
    logic [TAW-1:0]         ex_waddr = '0;
    logic [TDW-1:0]         ex_wdata = EXV;
    logic                   ex_is_load = 1'b0;
    logic                   mem_wreg = 1'b0;
    logic [TAW-1:0]         mem_waddr = '0;
    logic [TDW-1:0]         mem_wdata = MEMV;
    logic [5:0]             stall_vec;
    logic [5:0]             nop_inject;
    logic [TNP*TDW-1:0]     operand;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    hz_pipe_ctrl #(
        .AW     (TAW),
        .DW     (TDW),
        .NPORTS (TNP)
    ) u0 (
        .dec_stall_req (dec_stall_req),
        .exe_stall_req (exe_stall_req),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .rf_rdata      (rf_rdata),
        .ex_wreg       (ex_wreg),
        .ex_waddr      (ex_waddr),
        .ex_wdata      (ex_wdata),
        .ex_is_load    (ex_is_load),
        .mem_wreg      (mem_wreg),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .stall_vec     (stall_vec),
        .nop_inject    (nop_inject),
        .operand       (operand)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [TDW-1:0] rf_val(input int p, input int a);
        return 8'(32'hA0 + 4 * p + a);
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // R1: quiet state after start
        chk("R1 idle stall", 32'(stall_vec), 32'h0);
        chk("R1 idle nop", 32'(nop_inject), 32'h0);

        for (int ea0 = 0; ea0 < 8; ea0++) begin
            for (int ea1 = 0; ea1 < 8; ea1++) begin
                for (int exc = 0; exc < 16; exc++) begin
                    for (int mc = 0; mc < 8; mc++) begin
                        for (int rq = 0; rq < 4; rq++) begin
                            logic [TAW-1:0] a [TNP];
                            logic           en [TNP];
                            logic           lu;
                            logic [5:0]     es;
                            logic [5:0]     en_nop;
                            string          t;
                            a[0]  = 2'(ea0);
                            en[0] = ea0[2];
                            a[1]  = 2'(ea1);
                            en[1] = ea1[2];
                            @(posedge clk);
                            dec_stall_req = rq[0];
                            exe_stall_req = rq[1];
                            rd_en     = {en[1], en[0]};
                            rd_addr   = {a[1], a[0]};
                            rf_rdata  = {rf_val(1, ea1 % 4), rf_val(0, ea0 % 4)};
                            ex_waddr  = 2'(exc);
                            ex_wreg   = exc[2];
                            ex_is_load = exc[3];
                            mem_waddr = 2'(mc);
                            mem_wreg  = mc[2];
                            #1;
                            lu = exc[3] && exc[2] && (2'(exc) != 2'd0) &&
                                 ((en[0] && a[0] == 2'(exc)) || (en[1] && a[1] == 2'(exc)));
                            if (rq[1]) begin
                                es = 6'b001111; en_nop = 6'b010000; t = "R3";
                            end else if (rq[0] || lu) begin
                                es = 6'b000111; en_nop = 6'b001000;
                                t = (lu && !rq[0]) ? "R5" : "R2";
                            end else begin
                                es = 6'b000000; en_nop = 6'b000000;
                                t = exc[3] ? "R6" : "R1";
                            end
                            chk({t, " stall"}, 32'(stall_vec), 32'(es));
                            chk({t, " nop"}, 32'(nop_inject), 32'(en_nop));
                            // R4: thermometer shape of the freeze vector
                            chk("R4 prefix", 32'((stall_vec + 6'd1) & stall_vec), 32'h0);
                            for (int p = 0; p < TNP; p++) begin
                                logic [TDW-1:0] eo;
                                string          ot;
                                if (a[p] == 2'd0) begin
                                    eo = '0; ot = "R10";
                                end else if (!en[p]) begin
                                    eo = rf_val(p, int'(a[p])); ot = "R11";
                                end else if (exc[2] && 2'(exc) == a[p]) begin
                                    eo = EXV; ot = "R7";
                                end else if (mc[2] && 2'(mc) == a[p]) begin
                                    eo = MEMV; ot = "R8";
                                end else begin
                                    eo = rf_val(p, int'(a[p])); ot = "R9";
                                end
                                chk({ot, " operand"}, 32'(operand[p*TDW +: TDW]), 32'(eo));
                            end
                        end
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule